// File: doc/BRIEF.md
# Locked Rotor Retry Controller

This block supervises a Hall-sensed brushless fan or motor and decides when a stalled rotor should be given up on and when it should be tried again. It counts prescaled ticks since the last Hall transition strobe. If the count reaches the active detection window, it declares a stall. The window comes from a start-up setting while `run_phase` is low and from a run setting while it is high. On a stall it turns the bridge drive off, which the power stage treats as all switches in high impedance, and raises the fault flag.

After a stall it works through a two-tier schedule. First come a number of quick retries, each lasting one start-up window. Then comes a long backoff of a multiplier times the start-up window, and the pattern repeats. The first start-up cycle after reset or wake takes its quick-retry count from one field, and every later cycle takes it from another. Each retry wait ends with a one-cycle start request that hands control back to the start-up sequence at its pre-start phase. A stall in steady run goes straight to one long backoff. An optional latch mode gives up for good after five consecutive failed starts, and only a wake pulse or reset recovers from it.

Top module: `lrr_ctrl`

## Requirements
- R1: With `run_phase` low and `drv_en` high, `det_start` ticks without a `hall_edge` cause a stall. A stall drives `drv_en` low and `fault` high on the following cycle. The count is taken from reset release, from the end of a retry wait, or from the cycle after the last sampled `hall_edge`.
- R2: With `run_phase` high, the stall window is `det_run` ticks instead of `det_start`.
- R3: A `hall_edge` sampled while `drv_en` is high clears `fault` on the next cycle and restarts the window. Until such an edge arrives, `fault` stays high.
- R4: In the first start-up cycle after reset or wake, the first `nretry_first` stalls are each followed by a quick wait of `det_start` ticks. The wait ends with `start_req` high for exactly one cycle, in the same cycle that `drv_en` returns high.
- R5: Once the quick retries of a cycle are used up, the next start-up stall is followed by a long wait of `long_mult` times `det_start` ticks, which then ends with a start request.
- R6: Every start-up cycle after the first long wait allows `nretry_later` quick retries before the next long wait.
- R7: A stall with `run_phase` high goes straight to one long wait, then issues a start request. The cycles that follow use `nretry_later`.
- R8: With `retry_dis` at 1, the fifth consecutive start-up stall (no `hall_edge` in between) latches the fault: `drv_en` stays low, `fault` stays high and no `start_req` is issued. With `retry_dis` at 0, the schedule never latches.
- R9: Reset or a `wake` pulse gives `drv_en` high, `fault` low and `start_req` low on the next cycle. It also clears the retry and failure counts and makes the next cycle use `nretry_first` again.
- R10: A `hall_edge` during a quick or long wait is ignored: `fault` and `drv_en` stay unchanged and the wait ends on schedule.
- R11: Windows and waits advance only on cycles with `tick` high. With `tick` held low, no stall is ever declared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle timebase strobe |
| hall_edge | input | 1 | Single-cycle Hall transition strobe |
| run_phase | input | 1 | 1 = steady run, 0 = start-up |
| wake | input | 1 | Sleep-exit pulse, clears all retry state |
| retry_dis | input | 1 | 1 = latch after five failed starts |
| det_start | input | DET_W | Start-up window in ticks |
| det_run | input | DET_W | Run window in ticks |
| nretry_first | input | CNT_W | Quick retries in first start-up cycle |
| nretry_later | input | CNT_W | Quick retries in later cycles |
| long_mult | input | MULT_W | Long-wait multiplier of det_start |
| drv_en | output | 1 | Bridge drive enable (0 = all switches off) |
| start_req | output | 1 | One-cycle restart request |
| fault | output | 1 | Locked-rotor fault indicator |

## Verification
The bench measures the gap from each stall to the start request that follows it. With three first-cycle quick retries and one later retry, the gaps must run 4,4,4,12,4,12. A design that kept the first-cycle count forever, or reset it at every long wait, would show a different pattern. A run-phase stall must produce a long gap first and must drop the first-cycle count; a design that did a quick retry there would show a short first gap. Latch mode is probed at exactly the fifth stall, after four start requests, and wake must bring back the first-cycle pattern. Hall strobes inside a wait must leave the restart timing intact, and a wrongly scaled timebase shows up as a window length that is off.

// File: rtl/lrr_pkg.sv
package lrr_pkg;

    typedef enum logic [1:0] {
        ST_MON   = 2'd0,
        ST_QUICK = 2'd1,
        ST_LONG  = 2'd2,
        ST_LATCH = 2'd3
    } lrr_state_e;

endpackage

// File: rtl/lrr_window.sv
module lrr_window
    import lrr_pkg::*;
#(
    parameter int DET_W  = 12,
    parameter int MULT_W = 4,
    localparam int TIM_W = DET_W + MULT_W
) (
    input  lrr_state_e        state,
    input  logic              run_phase,
    input  logic [DET_W-1:0]  det_start,
    input  logic [DET_W-1:0]  det_run,
    input  logic [MULT_W-1:0] long_mult,
    output logic [TIM_W-1:0]  limit
);

    logic [TIM_W-1:0] start_w;
    logic [TIM_W-1:0] run_w;
    logic [TIM_W-1:0] mult_w;

    // zero settings behave as one tick / one multiple
    always_comb begin
        start_w = (det_start == '0) ? TIM_W'(1) : TIM_W'(det_start);
        run_w   = (det_run   == '0) ? TIM_W'(1) : TIM_W'(det_run);
        mult_w  = (long_mult == '0) ? TIM_W'(1) : TIM_W'(long_mult);
        case (state)
            ST_MON:   limit = run_phase ? run_w : start_w;
            ST_LONG:  limit = TIM_W'(mult_w * start_w);
            default:  limit = start_w;
        endcase
    end

endmodule

// File: rtl/lrr_retry_budget.sv
module lrr_retry_budget #(
    parameter int CNT_W = 4
) (
    input  logic             first,
    input  logic [CNT_W-1:0] nretry_first,
    input  logic [CNT_W-1:0] nretry_later,
    input  logic [CNT_W-1:0] used,
    output logic             quick_ok
);

    logic [CNT_W-1:0] quota;

    always_comb begin
        quota    = first ? nretry_first : nretry_later;
        quick_ok = (used < quota);
    end

endmodule

// File: rtl/lrr_tick_timer.sv
module lrr_tick_timer #(
    parameter int TIM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [TIM_W-1:0] limit,
    output logic             expire
);

    logic [TIM_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = tick && !clr && (cnt_q >= (limit - TIM_W'(1)));
        cnt_d  = cnt_q;
        if (clr || expire) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + TIM_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/lrr_ctrl.sv
module lrr_ctrl
    import lrr_pkg::*;
#(
    parameter int DET_W       = 12,
    parameter int CNT_W       = 4,
    parameter int MULT_W      = 4,
    parameter int LATCH_AFTER = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hall_edge,
    input  logic              run_phase,
    input  logic              wake,
    input  logic              retry_dis,
    input  logic [DET_W-1:0]  det_start,
    input  logic [DET_W-1:0]  det_run,
    input  logic [CNT_W-1:0]  nretry_first,
    input  logic [CNT_W-1:0]  nretry_later,
    input  logic [MULT_W-1:0] long_mult,
    output logic              drv_en,
    output logic              start_req,
    output logic              fault
);

    localparam int TIM_W  = DET_W + MULT_W;
    localparam int FAIL_W = $clog2(LATCH_AFTER + 1);

    typedef struct packed {
        lrr_state_e        state;
        logic              fault;
        logic              start;
        logic              first;
        logic [CNT_W-1:0]  used;
        logic [FAIL_W-1:0] fails;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        state: ST_MON, fault: 1'b0, start: 1'b0, first: 1'b1,
        used: '0, fails: '0
    };

    ctl_t              ctl_d, ctl_q;
    logic              tmr_clr;
    logic              tmr_exp;
    logic              quick_ok;
    logic [TIM_W-1:0]  limit;
    logic [FAIL_W-1:0] fails_inc;

    lrr_window #(.DET_W(DET_W), .MULT_W(MULT_W)) u_window (
        .state     (ctl_q.state),
        .run_phase (run_phase),
        .det_start (det_start),
        .det_run   (det_run),
        .long_mult (long_mult),
        .limit     (limit)
    );

    lrr_retry_budget #(.CNT_W(CNT_W)) u_budget (
        .first        (ctl_q.first),
        .nretry_first (nretry_first),
        .nretry_later (nretry_later),
        .used         (ctl_q.used),
        .quick_ok     (quick_ok)
    );

    lrr_tick_timer #(.TIM_W(TIM_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .clr    (tmr_clr),
        .limit  (limit),
        .expire (tmr_exp)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.start = 1'b0;
        tmr_clr     = 1'b0;
        fails_inc   = (ctl_q.fails >= FAIL_W'(LATCH_AFTER))
                      ? ctl_q.fails : ctl_q.fails + FAIL_W'(1);

        if (wake) begin
            ctl_d   = CTL_RESET;
            tmr_clr = 1'b1;
        end else begin
            case (ctl_q.state)
                ST_MON: begin
                    if (hall_edge) begin
                        // rotor proven turning: restart window, forget failures
                        ctl_d.fault = 1'b0;
                        ctl_d.used  = '0;
                        ctl_d.fails = '0;
                        tmr_clr     = 1'b1;
                    end else if (tmr_exp) begin
                        ctl_d.fault = 1'b1;
                        if (run_phase) begin
                            // stall in steady run: one long backoff first
                            ctl_d.state = ST_LONG;
                            ctl_d.first = 1'b0;
                            ctl_d.used  = '0;
                        end else begin
                            ctl_d.fails = fails_inc;
                            if (retry_dis && (fails_inc >= FAIL_W'(LATCH_AFTER))) begin
                                ctl_d.state = ST_LATCH;
                            end else if (quick_ok) begin
                                ctl_d.state = ST_QUICK;
                                ctl_d.used  = ctl_q.used + CNT_W'(1);
                            end else begin
                                ctl_d.state = ST_LONG;
                                ctl_d.first = 1'b0;
                                ctl_d.used  = '0;
                            end
                        end
                    end
                end
                ST_QUICK, ST_LONG: begin
                    if (tmr_exp) begin
                        ctl_d.state = ST_MON;
                        ctl_d.start = 1'b1;
                    end
                end
                default: begin
                    // latched: held until wake or reset
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign drv_en    = (ctl_q.state == ST_MON);
    assign start_req = ctl_q.start;
    assign fault     = ctl_q.fault;

endmodule

// File: rtl/lrr_checker.sv
module lrr_checker (
    input logic clk,
    input logic rst_n,
    input logic hall_edge,
    input logic wake,
    input logic drv_en,
    input logic start_req,
    input logic fault
);

    // R1: drive is off only while a fault is flagged
    p_off_implies_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en |-> fault)
        else $error("drive off without fault");

    // R4: start request lasts one cycle
    p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |=> !start_req)
        else $error("start request longer than one cycle");

    // R4: start request coincides with drive returning after being off
    p_start_reenables_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |-> (drv_en && !$past(drv_en)))
        else $error("start request without drive re-enable");

    // R3: hall strobe while driving clears the fault
    p_hall_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hall_edge && drv_en) |=> !fault)
        else $error("fault not cleared by hall strobe");

    // R9: wake restores the idle driving state
    p_wake_restores_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> (drv_en && !fault && !start_req))
        else $error("wake did not restore state");

endmodule

bind lrr_ctrl lrr_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hall_edge (hall_edge),
    .wake      (wake),
    .drv_en    (drv_en),
    .start_req (start_req),
    .fault     (fault)
);

// File: tb/sim_lrr_ctrl.sv
module sim_lrr_ctrl;

    localparam int D  = 4;   // det_start
    localparam int RW = 6;   // det_run
    localparam int NF = 3;   // nretry_first
    localparam int NL = 1;   // nretry_later
    localparam int M  = 3;   // long_mult

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        hall_edge = 1'b0;
    logic        run_phase = 1'b0;
    logic        wake = 1'b0;
    logic        retry_dis = 1'b0;
    logic [11:0] det_start = 12'(D);
    logic [11:0] det_run = 12'(RW);
    logic [3:0]  nretry_first = 4'(NF);
    logic [3:0]  nretry_later = 4'(NL);
    logic [3:0]  long_mult = 4'(M);
    logic        drv_en, start_req, fault;

    lrr_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hall_edge(hall_edge),
        .run_phase(run_phase), .wake(wake), .retry_dis(retry_dis),
        .det_start(det_start), .det_run(det_run),
        .nretry_first(nretry_first), .nretry_later(nretry_later),
        .long_mult(long_mult), .drv_en(drv_en), .start_req(start_req),
        .fault(fault)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int tick_div = 1;
    int tph = 0;
    always @(negedge clk) begin
        if (tick_div == 0) begin
            tick <= 1'b0;
        end else begin
            tick <= (tph == 0);
            tph  <= (tph + 1 >= tick_div) ? 0 : tph + 1;
        end
    end

    int fall_t [64];
    int st_t [64];
    int nf = 0;
    int ns = 0;
    logic prev_drv = 1'b1;
    always @(negedge clk) begin
        if (prev_drv && !drv_en && nf < 64) begin
            fall_t[nf] = cyc;
            nf++;
        end
        if (start_req && ns < 64) begin
            st_t[ns] = cyc;
            ns++;
        end
        prev_drv = drv_en;
    end

    int checks = 0;
    int errors = 0;
    int rel = 0;
    bit done = 1'b0;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_log();
        nf = 0;
        ns = 0;
    endtask

    task automatic do_reset(bit rdis);
        retry_dis = rdis;
        run_phase = 1'b0;
        hall_edge = 1'b0;
        wake      = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        clear_log();
        rst_n = 1'b1;
        rel = cyc;
    endtask

    task automatic wait_falls(int n);
        for (int i = 0; i < 300 && nf < n; i++) @(negedge clk);
    endtask

    // pulse lasts one cycle; returns the cycle number at which it was raised
    task automatic pulse_hall(output int hc);
        hall_edge = 1'b1;
        hc = cyc;
        @(negedge clk);
        hall_edge = 1'b0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset drv_en", int'(drv_en), 1);
        check("R9 reset fault", int'(fault), 0);
        check("R9 reset start_req", int'(start_req), 0);
    endtask

    task automatic t_startup_schedule();
        int exp_gap [6] = '{D, D, D, M*D, D, M*D};
        do_reset(1'b0);
        wait_falls(1);
        check("R1 first stall delay", fall_t[0] - rel, D);
        check("R1 drv_en off", int'(drv_en), 0);
        check("R1 fault on", int'(fault), 1);
        repeat (120) @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            if (i < 3) check("R4 quick gap", st_t[i] - fall_t[i], exp_gap[i]);
            else if (i == 3) check("R5 long gap", st_t[i] - fall_t[i], exp_gap[i]);
            else check("R6 later gap", st_t[i] - fall_t[i], exp_gap[i]);
            check("R1 restart window", fall_t[i+1] - st_t[i], D);
        end
        check("R8 no latch when disabled", int'(ns >= 7), 1);
    endtask

    task automatic t_run_stall();
        int hc;
        do_reset(1'b0);
        for (int i = 0; i < 5; i++) begin
            pulse_hall(hc);
            @(negedge clk);
        end
        run_phase = 1'b1;
        for (int i = 0; i < 5; i++) begin
            pulse_hall(hc);
            @(negedge clk);
        end
        check("R3 no stall while turning", nf, 0);
        wait_falls(1);
        run_phase = 1'b0;
        // hall sampled at edge hc+1, window counts from there
        check("R2 run window", fall_t[0] - hc, RW + 1);
        repeat (60) @(negedge clk);
        check("R7 run stall long first", st_t[0] - fall_t[0], M*D);
        check("R7 later quick count", st_t[1] - fall_t[1], D);
        check("R7 later long", st_t[2] - fall_t[2], M*D);
    endtask

    task automatic t_hall_clears();
        int hc;
        do_reset(1'b0);
        for (int i = 0; i < 100 && !start_req; i++) @(negedge clk);
        pulse_hall(hc);
        check("R3 fault cleared", int'(fault), 0);
        check("R3 drive kept", int'(drv_en), 1);
        repeat (20) @(negedge clk);
        check("R3 window restarted", fall_t[1] - hc, D + 1);
    endtask

    task automatic t_hall_in_wait();
        int hc;
        do_reset(1'b0);
        wait_falls(1);
        pulse_hall(hc);
        check("R10 fault held", int'(fault), 1);
        check("R10 drive held off", int'(drv_en), 0);
        repeat (20) @(negedge clk);
        check("R10 wait on schedule", st_t[0] - fall_t[0], D);
    endtask

    task automatic t_latch_and_wake();
        int wc;
        do_reset(1'b1);
        repeat (150) @(negedge clk);
        check("R8 starts before latch", ns, 4);
        check("R8 stalls before latch", nf, 5);
        check("R8 drive held off", int'(drv_en), 0);
        check("R8 fault held", int'(fault), 1);
        clear_log();
        wake = 1'b1;
        wc = cyc;
        @(negedge clk);
        wake = 1'b0;
        check("R9 wake drv_en", int'(drv_en), 1);
        check("R9 wake fault", int'(fault), 0);
        repeat (80) @(negedge clk);
        check("R9 wake window", fall_t[0] - wc, D + 1);
        check("R9 first count restored", st_t[2] - fall_t[2], D);
        check("R9 long after first count", st_t[3] - fall_t[3], M*D);
    endtask

    task automatic t_tick_scale();
        int act;
        tick_div = 3;
        do_reset(1'b0);
        wait_falls(1);
        act = fall_t[0] - rel;
        checks++;
        if (act < 3*D - 2 || act > 3*D) begin
            errors++;
            $display("FAIL R11 scaled window: actual=%0d expected=%0d..%0d", act, 3*D - 2, 3*D);
        end
        tick_div = 0;
        do_reset(1'b0);
        repeat (60) @(negedge clk);
        check("R11 no tick no stall", nf, 0);
        check("R11 fault stays low", int'(fault), 0);
        tick_div = 1;
    endtask

    initial begin
        t_reset_state();
        t_startup_schedule();
        t_run_stall();
        t_hall_clears();
        t_hall_in_wait();
        t_latch_and_wake();
        t_tick_scale();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule